// File: doc/BRIEF.md
# Masked Alarm Wake-Up Comparator

This block is the alarm stage of a real-time clock. On every count update it compares the live count vector against a programmed alarm value. A per-bit compare mask selects which bits take part. When the enabled bits agree, the block latches a level wake-up interrupt. Software writes the alarm value and the mask as two 32-bit halves each, through a simple write-only register port. A control register arms and disarms the alarm and clears the interrupt. A mode register holds these settings:

- calendar or binary interpretation of the count;
- wake-up enable;
- reset-on-wake-up;
- keep counting while the interrupt is pending.

The counter itself sits outside the block. The block only tells the counter when to clear and when to stop advancing. In calendar mode each date/time field is one byte wide, so clearing a mask byte turns that whole field into a don't-care. In binary mode, setting reset-on-wake-up makes the counter restart from zero at every match, which gives a periodic alarm.

Top module: `rtc_alarm_wake`

## Requirements
- R1: On a clock edge where `tick_i` is high, a match is found when ((count XOR alarm) AND mask) equals zero across all 64 bits. Any differing bit whose mask bit is 1 prevents the match, including bit 63. No match is looked for on cycles without `tick_i`.
- R2: A mask byte of 0x00 makes that byte a don't-care. A mask byte of 0xFF compares it. In calendar layout, the low word holds day, hour, minute and second in bytes 3 down to 0. The high word holds week, weekday, year and month in bytes 3 down to 0.
- R3: `wake_irq_o` rises one cycle after a matching tick and stays high, even when later ticks do not match. It falls one cycle after a control write with bit 8 set.
- R4: A control write with bit 2 set arms the alarm, and one with bit 3 set disarms it. When both bits are set, disarm wins. While disarmed, no match sets the interrupt.
- R5: While the wake-up enable bit (mode bit 1) is clear, no match sets the interrupt.
- R6: `cnt_reset_o` pulses high for exactly one cycle after a matching tick when mode bit 2 (reset on wake-up) is set and mode bit 0 is clear (binary mode). In calendar mode (bit 0 set) it never pulses.
- R7: While `wake_irq_o` is high and mode bit 3 (continue counting) is clear, `cnt_enable_o` is low. Otherwise it is high.
- R8: Register addresses are: 0 alarm low word, 1 alarm high word, 2 mask low word, 3 mask high word, 4 control, 5 mode. Mode bits [3:0] are loaded whole on a write to address 5.
- R9: After reset, all registers are zero, the alarm is disarmed, `wake_irq_o` and `cnt_reset_o` are low and `cnt_enable_o` is high.
- R10: When a matching tick and an interrupt-clear write fall in the same cycle, the match wins and the interrupt is left high.
- R11: A matching tick while the interrupt is already high still produces a new `cnt_reset_o` pulse, so a periodic alarm keeps restarting the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| tick_i | input | 1 | Count vector updated this cycle |
| count_i | input | 64 | Live count (binary value or packed calendar fields) |
| wake_irq_o | output | 1 | Latched wake-up interrupt |
| cnt_reset_o | output | 1 | One-cycle request to clear the counter |
| cnt_enable_o | output | 1 | Counter may advance |

## Verification
The comparator is driven with calendar counts in two groups. In the first, only don't-care bytes differ from the alarm, which shows that masked-off fields are truly ignored. In the second, one compared byte differs, which shows that enabled fields still block a match. Binary counts are applied under a full mask, first with only bit 63 flipped and then with bit 63 masked off, which tests the top end of the mask path. Gating patterns follow: a matching tick while disarmed, with both control bits at once, and with wake-up disabled. These separate a true match from the conditions that block the interrupt. The last patterns repeat a match while the interrupt is pending, once as a clear-plus-match collision and once in each mode. This shows the latch priority, the per-match reset pulse and the calendar/binary split of the reset request.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_ALARM_LO = 3'd0,
      RA_ALARM_HI = 3'd1,
      RA_MASK_LO  = 3'd2,
      RA_MASK_HI  = 3'd3,
      RA_CTRL     = 3'd4,
      RA_MODE     = 3'd5
   } reg_addr_e;

   // control register bit positions
   localparam int unsigned CTL_ARM_BIT    = 2;
   localparam int unsigned CTL_DISARM_BIT = 3;
   localparam int unsigned CTL_CLR_BIT    = 8;

   // mode register bit positions
   localparam int unsigned MOD_CAL_BIT  = 0;
   localparam int unsigned MOD_WKEN_BIT = 1;
   localparam int unsigned MOD_RST_BIT  = 2;
   localparam int unsigned MOD_CONT_BIT = 3;
   localparam int unsigned MODE_W       = 4;

   typedef struct packed {
      logic keep_count;   // bit 3
      logic rst_on_wake;  // bit 2
      logic wake_en;      // bit 1
      logic calendar;     // bit 0
   } mode_t;

endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned BUS_W = 32,
   parameter int unsigned WORDS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [BUS_W-1:0]         wr_data_i,
   output logic [WORDS*BUS_W-1:0]   alarm_o,
   output logic [WORDS*BUS_W-1:0]   mask_o,
   output logic                     armed_o,
   output mode_t                    mode_o,
   output logic                     clr_wake_o
);

   localparam logic [ADDR_W-1:0] ALARM_BASE = RA_ALARM_LO;
   localparam logic [ADDR_W-1:0] MASK_BASE  = RA_MASK_LO;

   logic ctrl_wr;
   logic mode_wr;

   assign ctrl_wr = wr_en_i && (wr_addr_i == RA_CTRL);
   assign mode_wr = wr_en_i && (wr_addr_i == RA_MODE);

   for (genvar k = 0; k < WORDS; k++) begin : g_word
      localparam logic [ADDR_W-1:0] A_ADDR = ALARM_BASE + ADDR_W'(k);
      localparam logic [ADDR_W-1:0] M_ADDR = MASK_BASE + ADDR_W'(k);
      logic [BUS_W-1:0] alarm_q;
      logic [BUS_W-1:0] mask_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            alarm_q <= '0;
            mask_q  <= '0;
         end else if (wr_en_i) begin
            if (wr_addr_i == A_ADDR) alarm_q <= wr_data_i;
            if (wr_addr_i == M_ADDR) mask_q  <= wr_data_i;
         end
      end

      assign alarm_o[k*BUS_W +: BUS_W] = alarm_q;
      assign mask_o[k*BUS_W +: BUS_W]  = mask_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_o <= 1'b0;
      end else if (ctrl_wr) begin
         if (wr_data_i[CTL_DISARM_BIT])   armed_o <= 1'b0;
         else if (wr_data_i[CTL_ARM_BIT]) armed_o <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mode_o <= '0;
      else if (mode_wr) mode_o <= mode_t'(wr_data_i[MODE_W-1:0]);
   end

   assign clr_wake_o = ctrl_wr && wr_data_i[CTL_CLR_BIT];

endmodule

// File: rtl/rtc_mask_match.sv
module rtc_mask_match #(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned LANE_W = 8
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] alarm_i,
   input  logic [CNT_W-1:0] mask_i,
   output logic             match_o
);

   localparam int unsigned LANES = CNT_W / LANE_W;

   logic [CNT_W-1:0] diff;
   assign diff = (count_i ^ alarm_i) & mask_i;

   if (LANE_W <= 1) begin : g_flat
      assign match_o = ~|diff;
   end else begin : g_lanes
      logic [LANES-1:0] lane_ok;
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign lane_ok[i] = ~|diff[i*LANE_W +: LANE_W];
      end
      assign match_o = &lane_ok;
   end

endmodule

// File: rtl/rtc_wake_ctrl.sv
module rtc_wake_ctrl
   import rtc_alarm_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  tick_i,
   input  logic  match_i,
   input  logic  armed_i,
   input  mode_t mode_i,
   input  logic  clr_i,
   output logic  wake_o,
   output logic  cnt_rst_o,
   output logic  cnt_en_o
);

   logic fire;
   assign fire = tick_i && armed_i && mode_i.wake_en && match_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wake_o    <= 1'b0;
         cnt_rst_o <= 1'b0;
      end else begin
         if (fire)       wake_o <= 1'b1;
         else if (clr_i) wake_o <= 1'b0;
         cnt_rst_o <= fire && mode_i.rst_on_wake && !mode_i.calendar;
      end
   end

   assign cnt_en_o = !(wake_o && !mode_i.keep_count);

endmodule

// File: rtl/rtc_alarm_wake.sv
module rtc_alarm_wake
   import rtc_alarm_pkg::*;
#(
   parameter int unsigned CNT_W  = 64,
   parameter int unsigned BUS_W  = 32,
   parameter int unsigned LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [2:0]        wr_addr_i,
   input  logic [BUS_W-1:0]  wr_data_i,
   input  logic              tick_i,
   input  logic [CNT_W-1:0]  count_i,
   output logic              wake_irq_o,
   output logic              cnt_reset_o,
   output logic              cnt_enable_o
);

   localparam int unsigned WORDS = CNT_W / BUS_W;

   initial begin
      assert (WORDS == 2 && CNT_W == WORDS * BUS_W)
         else $error("count must be exactly two bus words");
      assert (LANE_W >= 1 && CNT_W % LANE_W == 0)
         else $error("lane width must divide the count width");
      assert (BUS_W > CTL_CLR_BIT)
         else $error("bus too narrow for control bits");
   end

   logic [CNT_W-1:0] alarm_q;
   logic [CNT_W-1:0] mask_q;
   logic             armed_q;
   mode_t            mode_q;
   logic             clr_wake;
   logic             match;

   rtc_alarm_regs #(.BUS_W(BUS_W), .WORDS(WORDS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .alarm_o    (alarm_q),
      .mask_o     (mask_q),
      .armed_o    (armed_q),
      .mode_o     (mode_q),
      .clr_wake_o (clr_wake)
   );

   rtc_mask_match #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_match (
      .count_i (count_i),
      .alarm_i (alarm_q),
      .mask_i  (mask_q),
      .match_o (match)
   );

   rtc_wake_ctrl u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .match_i   (match),
      .armed_i   (armed_q),
      .mode_i    (mode_q),
      .clr_i     (clr_wake),
      .wake_o    (wake_irq_o),
      .cnt_rst_o (cnt_reset_o),
      .cnt_en_o  (cnt_enable_o)
   );

endmodule

// File: rtl/rtc_alarm_wake_chk.sv
module rtc_alarm_wake_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       wake,
   input logic       cnt_rst,
   input logic       cnt_en,
   input logic       armed,
   input logic [3:0] mode,
   input logic       clr
);

   p_wake_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wake && !clr |=> wake);

   p_wake_src_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake) |-> $past(tick));

   p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed || !mode[1]) && !wake |=> !wake);

   p_rst_with_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst |-> wake && $past(tick));

   p_rst_binary_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst |-> !$past(mode[0]));

   p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake && !mode[3] |-> !cnt_en);

endmodule

bind rtc_alarm_wake rtc_alarm_wake_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick    (tick_i),
   .wake    (wake_irq_o),
   .cnt_rst (cnt_reset_o),
   .cnt_en  (cnt_enable_o),
   .armed   (armed_q),
   .mode    (mode_q),
   .clr     (clr_wake)
);

// File: tb/rtc_alarm_wake_test.sv
module rtc_alarm_wake_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        tick = 1'b0;
   logic [63:0] count = '0;
   logic        wake, crst, cen;

   always #5 clk = ~clk;

   rtc_alarm_wake uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en_i      (wr_en),
      .wr_addr_i    (wr_addr),
      .wr_data_i    (wr_data),
      .tick_i       (tick),
      .count_i      (count),
      .wake_irq_o   (wake),
      .cnt_reset_o  (crst),
      .cnt_enable_o (cen)
   );

   int    n_run = 0;
   int    n_fail = 0;
   string tag = "R9";

   task automatic check(string t, string what, logic act, logic exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0b expected=%0b", t, what, act, exp);
      end
   endtask

   // behavioural reference model, updated on each rising edge
   logic [63:0] m_alarm, m_mask;
   logic        m_armed, m_wake, m_rst, m_hit;
   logic [3:0]  m_mode;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_alarm = '0; m_mask = '0; m_armed = 0; m_mode = '0;
         m_wake = 0; m_rst = 0;
      end else begin
         m_hit = tick && m_armed && m_mode[1] &&
                 (((count ^ m_alarm) & m_mask) == 64'd0);
         m_rst = m_hit && m_mode[2] && !m_mode[0];
         if (m_hit) m_wake = 1;
         else if (wr_en && wr_addr == 3'd4 && wr_data[8]) m_wake = 0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_alarm[31:0]  = wr_data;
               3'd1: m_alarm[63:32] = wr_data;
               3'd2: m_mask[31:0]   = wr_data;
               3'd3: m_mask[63:32]  = wr_data;
               3'd4: if (wr_data[3]) m_armed = 0;
                     else if (wr_data[2]) m_armed = 1;
               3'd5: m_mode = wr_data[3:0];
               default: ;
            endcase
         end
      end
   end

   always @(negedge clk) begin
      check(tag, "model wake", wake, m_wake);
      check(tag, "model cnt_reset", crst, m_rst);
      check(tag, "model cnt_enable", cen, !(m_wake && !m_mode[3]));
   end

   task automatic put(logic we, logic [2:0] a, logic [31:0] d, logic tk, logic [63:0] c);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d; tick = tk; count = c;
   endtask
   task automatic idle();               put(0, 3'd0, 32'd0, 0, count); endtask
   task automatic wr(logic [2:0] a, logic [31:0] d); put(1, a, d, 0, count); endtask
   task automatic tk(logic [63:0] c);   put(0, 3'd0, 32'd0, 1, c); endtask

   localparam logic [63:0] CAL_HIT = 64'hFFFF_FFFF_090C_1E07;
   localparam logic [63:0] BIN_HIT = 64'h0000_0123_0000_0010;

   task automatic finish_run();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R9", "reset wake", wake, 1'b0);
      check("R9", "reset cnt_reset", crst, 1'b0);
      check("R9", "reset cnt_enable", cen, 1'b1);
      rst_n = 1'b1;

      // calendar: compare hour and minute only
      tag = "R8";
      wr(3'd5, 32'hB);
      wr(3'd0, 32'h050C_1E00);
      wr(3'd2, 32'h00FF_FF00);
      wr(3'd4, 32'h4);
      tag = "R1";
      tk(64'h0000_0000_010C_1D3B); idle();
      check("R1", "minute differs, wake", wake, 1'b0);
      tag = "R2";
      tk(CAL_HIT); idle();
      check("R2", "don't-care bytes differ, wake", wake, 1'b1);
      tag = "R3";
      tk(64'd0); idle();
      check("R3", "wake holds past alarm", wake, 1'b1);
      wr(3'd4, 32'h100); idle();
      check("R3", "wake cleared", wake, 1'b0);

      tag = "R10";
      put(1, 3'd4, 32'h100, 1, CAL_HIT); idle();
      check("R10", "match beats clear", wake, 1'b1);
      wr(3'd4, 32'h100);

      tag = "R4";
      wr(3'd4, 32'hC); tk(CAL_HIT); idle();
      check("R4", "arm+disarm -> disarmed", wake, 1'b0);
      wr(3'd4, 32'h4); wr(3'd4, 32'h8); tk(CAL_HIT); idle();
      check("R4", "disarmed, wake", wake, 1'b0);
      wr(3'd4, 32'h4);

      tag = "R5";
      wr(3'd5, 32'h9); tk(CAL_HIT); idle();
      check("R5", "wake enable clear, wake", wake, 1'b0);
      check("R5", "cnt_enable", cen, 1'b1);

      // binary periodic alarm, full mask, no continue
      tag = "R6";
      wr(3'd5, 32'h6);
      wr(3'd0, 32'h10); wr(3'd1, 32'h123);
      wr(3'd2, 32'hFFFF_FFFF); wr(3'd3, 32'hFFFF_FFFF);
      tk(BIN_HIT); idle();
      check("R6", "reset pulse", crst, 1'b1);
      check("R7", "count held", cen, 1'b0);
      idle();
      check("R6", "pulse one cycle", crst, 1'b0);
      tag = "R11";
      tk(BIN_HIT); idle();
      check("R11", "repeat reset pulse", crst, 1'b1);
      check("R11", "wake still high", wake, 1'b1);
      wr(3'd4, 32'h100); idle();
      check("R7", "count resumes", cen, 1'b1);

      tag = "R1";
      tk(BIN_HIT | 64'h8000_0000_0000_0000); idle();
      check("R1", "bit 63 differs", wake, 1'b0);
      wr(3'd3, 32'h7FFF_FFFF);
      tk(BIN_HIT | 64'h8000_0000_0000_0000); idle();
      check("R1", "bit 63 masked", wake, 1'b1);
      wr(3'd4, 32'h100);

      tag = "R6";
      wr(3'd5, 32'h7); tk(BIN_HIT); idle();
      check("R6", "calendar mode no pulse", crst, 1'b0);
      check("R6", "calendar wake", wake, 1'b1);
      tag = "R7";
      wr(3'd5, 32'hF); idle();
      check("R7", "continue set", cen, 1'b1);
      idle();
      finish_run();
   end

endmodule